// File: doc/BRIEF.md
# Interrupt CSR Access Gate

This block sits in the execute stage of a processor core. It is called for every control/status register instruction. In the cycle a request is presented, it decides from the register address and the current privilege level whether the access is allowed. It also returns the value the register held before the access. On the next clock edge, it applies the read-modify-write to the interrupt registers it owns: the machine interrupt-enable, the interrupt-delegation and the machine pending registers, plus the supervisor views of the enable and pending registers.

Some rules come from the address alone. The minimum privilege and the read-only attribute are both encoded in fixed address fields. User counter addresses are allowed only when two counter-enable masks permit them, and these masks apply in turn as the privilege drops. The supervisor enable and pending registers hold no state of their own. They are windows onto the machine registers, filtered through the delegation register. Hardware interrupt lines feed the pending register directly. Software may change only the supervisor software and timer pending bits.

Privilege levels are encoded as 0 for user, 1 for supervisor and 3 for machine. Interrupt bit positions are as follows:

| Interrupt | Supervisor bit | Machine bit |
|---|---|---|
| Software | 1 | 3 |
| Timer | 5 | 7 |
| External | 9 | 11 |

Top module: `csr_irq_gate`

## Requirements
- R1: A request whose privilege is numerically below address bits 9:8 is flagged illegal.
- R2: When address bits 11:10 equal 3, any access with a nonzero write mask is illegal. An access to such an address with a zero mask (read, or set/clear with a zero operand) is legal.
- R3: Addresses 0xC00 to 0xC1F are user counters. Let n be address bits 4:0. From privilege below 3, bit n of `mcnt_en` must be set. From privilege 0, bit n of `scnt_en` must also be set. Otherwise the access is illegal. A legal counter access returns zero.
- R4: `req_op` selects the operation, and the new value is (old AND NOT mask) OR (data AND mask):

  | `req_op` | Operation | Data | Mask |
  |---|---|---|---|
  | 0 | read | none | zero (no write) |
  | 1 | write | operand | all-ones |
  | 2 | set | all-ones | operand |
  | 3 | clear | zero | operand |
- R5: `rd_data` shows, in the request cycle, the addressed view before the access. Register outputs change on the following rising clock edge.
- R6: At machine enable address 0x304, only bits 1, 3, 5, 7, 9 and 11 can be written. All other bits read zero.
- R7: At delegation address 0x303, only bits 1, 5 and 9 can be written.
- R8: The pending value at 0x344 is the stored software bits OR (`hw_irq` AND 0xAAA). Software writes change only bits 1 and 5. Bit 9 follows `hw_irq` bit 9 alone.
- R9: The supervisor enable view at 0x104 reads as enable AND delegation. A write to it changes only enable bits that are delegated.
- R10: The supervisor pending view at 0x144 reads as pending AND delegation. A write to it changes only software-writable bits that are also delegated.
- R11: An illegal access, including any address other than those listed in R3 and R6 to R10, leaves every register unchanged.
- R12: After synchronous active-low reset, the enable, delegation and software pending registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A CSR access is presented this cycle |
| req_addr | input | 12 | CSR address |
| req_priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| req_operand | input | XLEN | Source operand |
| mcnt_en | input | 32 | Machine counter-enable mask |
| scnt_en | input | 32 | Supervisor counter-enable mask |
| hw_irq | input | XLEN | Hardware-driven pending lines |
| rd_data | output | XLEN | Value of the addressed view before the access |
| illegal | output | 1 | The presented access must trap as illegal |
| ie_o | output | XLEN | Machine interrupt-enable register |
| deleg_o | output | XLEN | Interrupt-delegation register |
| pend_o | output | XLEN | Effective pending value |

## Verification
The bench builds the block with the default XLEN of 32. This puts operands well beyond the twelve interrupt bits, so all-ones writes and set/clear masks show that the upper bits are discarded.

The delegation register is reprogrammed between full, partial and empty patterns. This lets the supervisor views be checked against varying filters.

The counter-enable masks are swept over the combinations that separate the two cascaded conditions at each privilege level.

The hardware lines are toggled around software pending writes. This separates stored bits from driven bits.

// File: rtl/csr_irq_pkg.sv
// Shared constants and types for the interrupt CSR access gate.
// Assumes interrupt fields live in the low twelve bits of every register.
package csr_irq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MIE,
        SEL_MDEL,
        SEL_MPEND,
        SEL_SIE,
        SEL_SPEND,
        SEL_CNT
    } csr_sel_e;

    localparam logic [11:0] ADDR_MIE   = 12'h304;
    localparam logic [11:0] ADDR_MDEL  = 12'h303;
    localparam logic [11:0] ADDR_MPEND = 12'h344;
    localparam logic [11:0] ADDR_SIE   = 12'h104;
    localparam logic [11:0] ADDR_SPEND = 12'h144;
    localparam logic [6:0]  CNT_PAGE   = 7'b1100000;

    localparam int          IRQ_W      = 12;
    localparam logic [11:0] IRQ_ALL    = 12'hAAA;
    localparam logic [11:0] IRQ_SUP    = 12'h222;
    localparam logic [11:0] IRQ_SWPEND = 12'h022;

    localparam logic [1:0]  PRIV_U     = 2'd0;
    localparam logic [1:0]  PRIV_S     = 2'd1;
    localparam logic [1:0]  PRIV_M     = 2'd3;

endpackage

// File: rtl/csr_addr_decode.sv
// Address decoder: maps a 12-bit CSR address to the register view it names
// and splits out the address fields that govern access rights.
// Assumes nothing about privilege; purely combinational.
module csr_addr_decode
    import csr_irq_pkg::*;
(
    input  logic [11:0] addr,
    output csr_sel_e    sel,
    output logic [1:0]  min_priv,
    output logic        read_only,
    output logic [4:0]  cnt_idx
);

    // Field extraction for the rights check.
    assign min_priv  = addr[9:8];
    assign read_only = (addr[11:10] == 2'b11);
    assign cnt_idx   = addr[4:0];

    // Select which view the address hits.
    always_comb begin
        if (addr[11:5] == CNT_PAGE) sel = SEL_CNT;
        else begin
            unique case (addr)
                ADDR_MIE:   sel = SEL_MIE;
                ADDR_MDEL:  sel = SEL_MDEL;
                ADDR_MPEND: sel = SEL_MPEND;
                ADDR_SIE:   sel = SEL_SIE;
                ADDR_SPEND: sel = SEL_SPEND;
                default:    sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/csr_access_check.sv
// Rights check: combines address-encoded privilege, the read-only attribute,
// the two counter-enable masks and decode coverage into one illegal flag.
// Assumes the privilege encoding 0 user, 1 supervisor, 3 machine.
module csr_access_check
    import csr_irq_pkg::*;
(
    input  csr_sel_e    sel,
    input  logic [1:0]  min_priv,
    input  logic        read_only,
    input  logic [4:0]  cnt_idx,
    input  logic [1:0]  priv,
    input  logic        writes,
    input  logic [31:0] mcnt_en,
    input  logic [31:0] scnt_en,
    output logic        bad
);

    logic cnt_block;

    // Counter gating: machine mask below machine mode, both masks in user mode.
    always_comb begin
        cnt_block = 1'b0;
        if (priv < PRIV_M && !mcnt_en[cnt_idx]) cnt_block = 1'b1;
        if (priv < PRIV_S && !scnt_en[cnt_idx]) cnt_block = 1'b1;
    end

    // Any single violation makes the access illegal.
    always_comb begin
        bad = 1'b0;
        if (priv < min_priv)               bad = 1'b1;
        if (read_only && writes)           bad = 1'b1;
        if (sel == SEL_NONE)               bad = 1'b1;
        if (sel == SEL_CNT && cnt_block)   bad = 1'b1;
    end

endmodule

// File: rtl/csr_rmw_merge.sv
// Operation expander: turns the opcode and operand into a data/mask pair and
// merges it with the old value. Assumes a zero mask means "no write".
module csr_rmw_merge
    import csr_irq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e          op,
    input  logic [XLEN-1:0]  operand,
    input  logic [XLEN-1:0]  old_val,
    output logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  wmask,
    output logic [XLEN-1:0]  new_val
);

    // Expand the opcode into data and mask.
    always_comb begin
        unique case (op)
            OP_WRITE: begin wdata = operand; wmask = '1;      end
            OP_SET:   begin wdata = '1;      wmask = operand; end
            OP_CLEAR: begin wdata = '0;      wmask = operand; end
            default:  begin wdata = '0;      wmask = '0;      end
        endcase
    end

    // Bitwise merge of old and new.
    assign new_val = (old_val & ~wmask) | (wdata & wmask);

endmodule

// File: rtl/csr_irq_regs.sv
// Interrupt state: enable, delegation and software pending registers, with
// per-register write legalisation. Assumes commit is already qualified by
// legality and a nonzero mask.
module csr_irq_regs
    import csr_irq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  csr_sel_e         sel,
    input  logic [XLEN-1:0]  wdata,
    input  logic [XLEN-1:0]  wmask,
    input  logic [XLEN-1:0]  new_val,
    input  logic [XLEN-1:0]  hw_irq,
    output logic [XLEN-1:0]  ie_q,
    output logic [XLEN-1:0]  deleg_q,
    output logic [XLEN-1:0]  pend
);

    localparam logic [XLEN-1:0] ALL_X = XLEN'(IRQ_ALL);
    localparam logic [XLEN-1:0] SUP_X = XLEN'(IRQ_SUP);
    localparam logic [XLEN-1:0] SWP_X = XLEN'(IRQ_SWPEND);

    logic [XLEN-1:0] sw_q;
    logic [XLEN-1:0] ie_d, deleg_d, sw_d, pmask;

    // Pending write mask: software bits, further filtered for the supervisor view.
    assign pmask = (sel == SEL_SPEND) ? (wmask & SWP_X & deleg_q) : (wmask & SWP_X);

    // Next-state selection with legalisation per register.
    always_comb begin
        ie_d    = ie_q;
        deleg_d = deleg_q;
        sw_d    = sw_q;
        if (commit) begin
            unique case (sel)
                SEL_MIE:   ie_d    = new_val & ALL_X;
                SEL_SIE:   ie_d    = (ie_q & ~deleg_q) | (new_val & deleg_q & ALL_X);
                SEL_MDEL:  deleg_d = new_val & SUP_X;
                SEL_MPEND,
                SEL_SPEND: sw_d    = (sw_q & ~pmask) | (wdata & pmask);
                default:   ;
            endcase
        end
    end

    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= '0;
            deleg_q <= '0;
            sw_q    <= '0;
        end else begin
            ie_q    <= ie_d;
            deleg_q <= deleg_d;
            sw_q    <= sw_d;
        end
    end

    // Effective pending: stored software bits plus hardware lines.
    assign pend = sw_q | (hw_irq & ALL_X);

    a_r11_no_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ie_q) && $stable(deleg_q) && $stable(sw_q)));
    a_r7_deleg_sup_only: assert property (@(posedge clk) disable iff (!rst_n)
        (deleg_q & ~SUP_X) == '0);
    a_r6_ie_irq_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q & ~ALL_X) == '0);
    a_r8_seip_from_hw: assert property (@(posedge clk) disable iff (!rst_n)
        pend[9] == hw_irq[9]);

endmodule

// File: rtl/csr_irq_gate.sv
// Top of the interrupt CSR access gate: decodes the address, checks rights,
// returns the pre-access view and commits the read-modify-write on the next
// edge. Assumes one request per cycle, qualified by req_valid.
module csr_irq_gate
    import csr_irq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [11:0]      req_addr,
    input  logic [1:0]       req_priv,
    input  logic [1:0]       req_op,
    input  logic [XLEN-1:0]  req_operand,
    input  logic [31:0]      mcnt_en,
    input  logic [31:0]      scnt_en,
    input  logic [XLEN-1:0]  hw_irq,
    output logic [XLEN-1:0]  rd_data,
    output logic             illegal,
    output logic [XLEN-1:0]  ie_o,
    output logic [XLEN-1:0]  deleg_o,
    output logic [XLEN-1:0]  pend_o
);

    csr_sel_e        sel;
    logic [1:0]      min_priv;
    logic            read_only;
    logic [4:0]      cnt_idx;
    logic            bad, writes, commit;
    logic [XLEN-1:0] old_val, wdata, wmask, new_val;

    csr_addr_decode u_dec (
        .addr(req_addr), .sel(sel), .min_priv(min_priv),
        .read_only(read_only), .cnt_idx(cnt_idx)
    );

    csr_rmw_merge #(.XLEN(XLEN)) u_merge (
        .op(csr_op_e'(req_op)), .operand(req_operand), .old_val(old_val),
        .wdata(wdata), .wmask(wmask), .new_val(new_val)
    );

    assign writes = |wmask;

    csr_access_check u_chk (
        .sel(sel), .min_priv(min_priv), .read_only(read_only), .cnt_idx(cnt_idx),
        .priv(req_priv), .writes(writes), .mcnt_en(mcnt_en), .scnt_en(scnt_en),
        .bad(bad)
    );

    // Commit only legal requests that actually write.
    assign commit  = req_valid && !bad && writes;
    assign illegal = req_valid && bad;

    csr_irq_regs #(.XLEN(XLEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .sel(sel),
        .wdata(wdata), .wmask(wmask), .new_val(new_val), .hw_irq(hw_irq),
        .ie_q(ie_o), .deleg_q(deleg_o), .pend(pend_o)
    );

    // Pre-access view of the addressed register.
    always_comb begin
        unique case (sel)
            SEL_MIE:   old_val = ie_o;
            SEL_MDEL:  old_val = deleg_o;
            SEL_MPEND: old_val = pend_o;
            SEL_SIE:   old_val = ie_o & deleg_o;
            SEL_SPEND: old_val = pend_o & deleg_o;
            default:   old_val = '0;
        endcase
    end

    assign rd_data = old_val;

    a_r1_low_priv_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_priv < req_addr[9:8])) |-> illegal);
    a_r2_ro_write_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:10] == 2'b11 && req_op == 2'd1) |-> illegal);
    a_r11_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> ($stable(ie_o) && $stable(deleg_o)));
    a_r3_counter_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:5] == CNT_PAGE) |-> rd_data == '0);

endmodule

// File: tb/tb_csr_irq_gate.sv
module tb_csr_irq_gate;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [1:0]      req_priv = '0;
    logic [1:0]      req_op = '0;
    logic [XLEN-1:0] req_operand = '0;
    logic [31:0]     mcnt_en = '0;
    logic [31:0]     scnt_en = '0;
    logic [XLEN-1:0] hw_irq = '0;
    logic [XLEN-1:0] rd_data, ie_o, deleg_o, pend_o;
    logic            illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit monitor_on = 0;

    // Reference state, updated behaviourally.
    logic [31:0] m_ie = 0, m_del = 0, m_sw = 0;

    csr_irq_gate #(.XLEN(XLEN)) dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_pend();
        return (m_sw & 32'h022) | (hw_irq & 32'hAAA);
    endfunction

    // Compare register outputs with the model every clock.
    always @(negedge clk) begin
        if (monitor_on) begin
            #3;
            chk("R5 ie", ie_o, m_ie);
            chk("R5 deleg", deleg_o, m_del);
            chk("R8 pend", pend_o, ref_pend());
        end
    end

    task automatic access(input logic [11:0] a, input logic [1:0] p, input logic [1:0] o,
                          input logic [31:0] v, input string tag);
        logic        exp_bad;
        logic [31:0] old, wm, d, nv, k;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_priv = p; req_op = o; req_operand = v;
        #2;
        case (o)
            2'd1:    begin d = v;  wm = '1; end
            2'd2:    begin d = '1; wm = v;  end
            2'd3:    begin d = '0; wm = v;  end
            default: begin d = '0; wm = '0; end
        endcase
        exp_bad = 0;
        old = 0;
        if (a == 12'h304) old = m_ie;
        else if (a == 12'h303) old = m_del;
        else if (a == 12'h344) old = ref_pend();
        else if (a == 12'h104) old = m_ie & m_del;
        else if (a == 12'h144) old = ref_pend() & m_del;
        else if (a >= 12'hC00 && a <= 12'hC1F) begin
            if (p != 3 && !mcnt_en[a[4:0]]) exp_bad = 1;
            if (p == 0 && !scnt_en[a[4:0]]) exp_bad = 1;
        end else exp_bad = 1;
        if (p < a[9:8]) exp_bad = 1;
        if (a[11:10] == 2'b11 && wm != 0) exp_bad = 1;
        chk({tag, " illegal"}, {31'd0, illegal}, {31'd0, exp_bad});
        if (!exp_bad) chk({tag, " rd"}, rd_data, old);
        @(posedge clk);
        #1;
        req_valid = 0;
        if (!exp_bad) begin
            nv = (old & ~wm) | (d & wm);
            if (a == 12'h304) m_ie = nv & 32'hAAA;
            else if (a == 12'h104) m_ie = (m_ie & ~m_del) | (nv & m_del);
            else if (a == 12'h303) m_del = nv & 32'h222;
            else if (a == 12'h344 || a == 12'h144) begin
                k = wm & 32'h022;
                if (a == 12'h144) k = k & m_del;
                m_sw = (m_sw & ~k) | (d & k);
            end
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        @(negedge clk);
        #2;
        // R12 reset state
        chk("R12 ie", ie_o, 0);
        chk("R12 deleg", deleg_o, 0);
        chk("R12 pend", pend_o, 0);
        monitor_on = 1;

        // R6 enable legalisation, R5 old value returned
        access(12'h304, 2'd3, 2'd1, 32'hFFFF_FFFF, "R6");
        access(12'h304, 2'd3, 2'd0, 32'h0000_1234, "R5");
        access(12'h304, 2'd3, 2'd3, 32'h0000_0088, "R4 clear");
        access(12'h304, 2'd3, 2'd2, 32'h0000_0008, "R4 set");
        // R7 delegation legalisation
        access(12'h303, 2'd3, 2'd1, 32'hFFFF_FFFF, "R7");
        // R9 supervisor enable view
        access(12'h104, 2'd1, 2'd1, 32'h0, "R9 write");
        access(12'h104, 2'd1, 2'd2, 32'hFFF, "R9 set");
        access(12'h303, 2'd3, 2'd1, 32'h002, "R7 partial");
        access(12'h104, 2'd1, 2'd3, 32'hFFF, "R9 partial");
        // R1 privilege from address
        access(12'h304, 2'd0, 2'd0, 32'h0, "R1 user");
        access(12'h304, 2'd1, 2'd1, 32'hFFF, "R1 super");
        access(12'h104, 2'd0, 2'd2, 32'hFFF, "R1 user sview");
        // R11 unmapped address
        access(12'h7C0, 2'd3, 2'd1, 32'hFFF, "R11 unmapped");
        // R3 counter gating
        access(12'hC01, 2'd0, 2'd0, 32'h0, "R3 none");
        mcnt_en = 32'h2;
        access(12'hC01, 2'd0, 2'd0, 32'h0, "R3 m only user");
        access(12'hC01, 2'd1, 2'd0, 32'h0, "R3 m only super");
        scnt_en = 32'h2;
        access(12'hC01, 2'd0, 2'd0, 32'h0, "R3 both user");
        access(12'hC02, 2'd0, 2'd0, 32'h0, "R3 other bit");
        mcnt_en = 0;
        access(12'hC01, 2'd1, 2'd0, 32'h0, "R3 s no m");
        access(12'hC01, 2'd3, 2'd0, 32'h0, "R3 machine");
        // R2 read-only attribute
        access(12'hC00, 2'd3, 2'd1, 32'h0, "R2 write");
        access(12'hC00, 2'd3, 2'd2, 32'h0, "R2 set zero");
        access(12'hC00, 2'd3, 2'd3, 32'h1, "R2 clear nz");
        // R8 pending behaviour
        @(negedge clk); hw_irq = 32'hFFFF_FFFF;
        access(12'h344, 2'd3, 2'd0, 32'h0, "R8 hw read");
        access(12'h344, 2'd3, 2'd1, 32'h0, "R8 write zero");
        @(negedge clk); hw_irq = 32'h0;
        access(12'h344, 2'd3, 2'd2, 32'hFFFF_FFFF, "R8 set all");
        access(12'h344, 2'd3, 2'd0, 32'h0, "R8 readback");
        // R10 supervisor pending view
        access(12'h144, 2'd1, 2'd0, 32'h0, "R10 read");
        access(12'h144, 2'd1, 2'd3, 32'hFFF, "R10 clear partial");
        access(12'h303, 2'd3, 2'd1, 32'h222, "R7 full");
        access(12'h144, 2'd1, 2'd3, 32'hFFF, "R10 clear full");
        access(12'h144, 2'd1, 2'd2, 32'hFFF, "R10 set full");
        @(negedge clk); hw_irq = 32'h200;
        access(12'h144, 2'd1, 2'd3, 32'h200, "R8 seip hw");
        access(12'h144, 2'd1, 2'd0, 32'h0, "R10 read hw");
        // R11 illegal leaves state
        access(12'h303, 2'd1, 2'd1, 32'h0, "R11 illegal deleg");
        repeat (2) @(negedge clk);
        monitor_on = 0;
        #5;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule